// File: doc/BRIEF.md
# Multi-Image Boot Selection Controller

This block decides which stored boot image a processor starts from after a reset. It keeps an index of the image that was last handed control, and a state word that software can write. An external image loader receives a load request with an index. The loader answers with a done strobe and a checksum-pass flag. When an image passes, the block raises a handoff strobe with the winning index. When every candidate has been rejected, it raises a fallback-select level so that the secondary boot source is used instead of flash.

A cold reset request always restarts the search at image 0. A warm reset request behaves in one of three ways:
- If the state word holds the proof value 0x49535756, the image recorded as last loaded is loaded again.
- If the proof value is absent, the search moves on to the following image.
- If fallback is already active, the request changes nothing.

The block clears the state word at every handoff. The stage that was booted must therefore write the proof value again to show that it ran. Fallback is sticky: only a cold reset request brings flash images back into play. A warm request that arrives before any cold request has been seen is treated as a cold one.

Top module: `boot_img_sel`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `ld_req`, `handoff` and `fallback_sel` are 0, and `last_idx` and `state_word` are 0.
- R2: A cold request raises `ld_req` with `ld_idx` = 0 one cycle later, and `fallback_sel` is 0 in that cycle. `ld_req` drops on the following cycle unless a new load is started.
- R3: A done strobe with pass = 1 while a load is pending gives a one-cycle `handoff` on the next cycle. In that cycle `handoff_idx` equals the loaded index, and `last_idx` already holds that same index.
- R4: A done strobe with pass = 0 for an index below NUM_IMG-1 raises `ld_req` on the next cycle with that index plus one.
- R5: A done strobe with pass = 0 for index NUM_IMG-1 sets `fallback_sel` on the next cycle, with no `ld_req` and no `handoff`.
- R6: A warm request after a cold request has been seen, with `state_word` = 0x49535756 and fallback inactive, raises `ld_req` one cycle later with `ld_idx` = `last_idx`.
- R7: A warm request without that value, with fallback inactive and `last_idx` below NUM_IMG-1, raises `ld_req` one cycle later with `last_idx`+1. `last_idx` becomes that index in the same cycle.
- R8: A warm request without that value while `last_idx` = NUM_IMG-1 sets `fallback_sel` one cycle later and issues no load.
- R9: Once `fallback_sel` is 1, warm requests and done strobes leave it at 1 and issue neither `ld_req` nor `handoff`, even when the proof value is present. Only a cold request clears it.
- R10: `sw_wr_en` loads `sw_wr_data` into `state_word` on the next cycle. `state_word` reads 0 in the cycle `handoff` is high. When a write and a handoff fall in the same cycle, the clear wins.
- R11: A warm request before any cold request acts as a cold request and loads index 0, even when the proof value is present.
- R12: A cold and a warm request in the same cycle behave as a cold request. A reset request arriving together with a done strobe takes precedence, and the strobe is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cold_rst_req | input | 1 | One-cycle cold reset request |
| warm_rst_req | input | 1 | One-cycle warm reset request |
| ld_req | output | 1 | One-cycle load-and-verify request to the image loader |
| ld_idx | output | IDX_W | Image index carried with `ld_req` |
| ld_done | input | 1 | One-cycle completion strobe from the loader |
| ld_pass | input | 1 | Checksum verdict, valid with `ld_done` |
| sw_wr_en | input | 1 | State word write enable |
| sw_wr_data | input | SW_W | State word write data |
| state_word | output | SW_W | Current state word |
| last_idx | output | IDX_W | Last-loaded image index |
| handoff | output | 1 | One-cycle control handoff strobe |
| handoff_idx | output | IDX_W | Index of the image receiving control |
| fallback_sel | output | 1 | Secondary boot source selected (sticky) |

## Verification
Two pairs of events can land in the same cycle and need a defined winner. In the first pair, a reset request meets the loader's done strobe. The bench raises a warm request with the proof value present in exactly the cycle a passing done arrives. It expects a reload of the recorded index and no handoff. In the second pair, a software write to the state word meets the handoff clear. The bench drives a write of the proof value in the cycle a passing done arrives. It expects `state_word` to read 0 both in the handoff cycle and in the cycle after. Simultaneous cold and warm requests are also driven, and they must start at index 0 with fallback cleared.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_VERIFY,
    ST_BOOTED,
    ST_FALLBACK
  } bsel_state_e;

  localparam logic [31:0] BSEL_PROOF = 32'h4953_5756;

endpackage

// File: rtl/bsel_state_word.sv
module bsel_state_word #(
  parameter int          SW_W  = 32,
  parameter logic [31:0] PROOF = 32'h4953_5756
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [SW_W-1:0] wr_data,
  input  logic            clr,
  output logic [SW_W-1:0] word,
  output logic            proof_ok
);

  localparam logic [SW_W-1:0] PROOF_W = SW_W'(PROOF);

  always_ff @(posedge clk) begin
    if (rst)        word <= '0;
    else if (clr)   word <= '0;      // handoff clear beats a same-cycle write
    else if (wr_en) word <= wr_data;
  end

  assign proof_ok = (word == PROOF_W);

endmodule

// File: rtl/bsel_seq.sv
module bsel_seq
  import boot_sel_pkg::*;
#(
  parameter int NUM_IMG = 4,
  parameter int IDX_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cold_req,
  input  logic             warm_req,
  input  logic             proof_ok,
  input  logic             ld_done,
  input  logic             ld_pass,
  output logic             ld_req,
  output logic [IDX_W-1:0] ld_idx,
  output logic             handoff,
  output logic [IDX_W-1:0] handoff_idx,
  output logic [IDX_W-1:0] last_idx,
  output logic             fallback_sel,
  output logic             sw_clr
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_IMG - 1);
  localparam logic [IDX_W-1:0] ONE_IDX = IDX_W'(1);

  bsel_state_e      state;
  logic [IDX_W-1:0] cur_idx;
  logic             cold_seen;
  logic             start_cold;
  logic             verdict;

  assign start_cold = cold_req || (warm_req && !cold_seen);
  assign verdict    = (state == ST_VERIFY) && ld_done && !cold_req && !warm_req;
  assign sw_clr     = verdict && ld_pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cur_idx      <= '0;
      last_idx     <= '0;
      ld_req       <= 1'b0;
      ld_idx       <= '0;
      handoff      <= 1'b0;
      handoff_idx  <= '0;
      fallback_sel <= 1'b0;
      cold_seen    <= 1'b0;
    end else begin
      ld_req  <= 1'b0;
      handoff <= 1'b0;
      if (start_cold) begin
        cold_seen    <= 1'b1;
        fallback_sel <= 1'b0;
        cur_idx      <= '0;
        ld_req       <= 1'b1;
        ld_idx       <= '0;
        state        <= ST_VERIFY;
      end else if (warm_req) begin
        if (fallback_sel) begin
          state <= ST_FALLBACK;
        end else if (proof_ok) begin
          cur_idx <= last_idx;
          ld_req  <= 1'b1;
          ld_idx  <= last_idx;
          state   <= ST_VERIFY;
        end else if (last_idx == TOP_IDX) begin
          fallback_sel <= 1'b1;
          state        <= ST_FALLBACK;
        end else begin
          cur_idx  <= last_idx + ONE_IDX;
          last_idx <= last_idx + ONE_IDX;
          ld_req   <= 1'b1;
          ld_idx   <= last_idx + ONE_IDX;
          state    <= ST_VERIFY;
        end
      end else if (verdict) begin
        if (ld_pass) begin
          last_idx    <= cur_idx;
          handoff     <= 1'b1;
          handoff_idx <= cur_idx;
          state       <= ST_BOOTED;
        end else if (cur_idx == TOP_IDX) begin
          fallback_sel <= 1'b1;
          state        <= ST_FALLBACK;
        end else begin
          cur_idx <= cur_idx + ONE_IDX;
          ld_req  <= 1'b1;
          ld_idx  <= cur_idx + ONE_IDX;
        end
      end
    end
  end

endmodule

// File: rtl/boot_img_sel.sv
module boot_img_sel
  import boot_sel_pkg::*;
#(
  parameter int          NUM_IMG = 4,
  parameter int          SW_W    = 32,
  parameter logic [31:0] PROOF   = BSEL_PROOF,
  localparam int         IDX_W   = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cold_rst_req,
  input  logic             warm_rst_req,
  output logic             ld_req,
  output logic [IDX_W-1:0] ld_idx,
  input  logic             ld_done,
  input  logic             ld_pass,
  input  logic             sw_wr_en,
  input  logic [SW_W-1:0]  sw_wr_data,
  output logic [SW_W-1:0]  state_word,
  output logic [IDX_W-1:0] last_idx,
  output logic             handoff,
  output logic [IDX_W-1:0] handoff_idx,
  output logic             fallback_sel
);

  logic proof_ok;
  logic sw_clr;

  bsel_state_word #(.SW_W(SW_W), .PROOF(PROOF)) u_word (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (sw_wr_en),
    .wr_data  (sw_wr_data),
    .clr      (sw_clr),
    .word     (state_word),
    .proof_ok (proof_ok)
  );

  bsel_seq #(.NUM_IMG(NUM_IMG), .IDX_W(IDX_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cold_req     (cold_rst_req),
    .warm_req     (warm_rst_req),
    .proof_ok     (proof_ok),
    .ld_done      (ld_done),
    .ld_pass      (ld_pass),
    .ld_req       (ld_req),
    .ld_idx       (ld_idx),
    .handoff      (handoff),
    .handoff_idx  (handoff_idx),
    .last_idx     (last_idx),
    .fallback_sel (fallback_sel),
    .sw_clr       (sw_clr)
  );

endmodule

// File: rtl/bsel_chk.sv
module bsel_chk #(
  parameter int IDX_W = 2,
  parameter int SW_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cold_rst_req,
  input logic             ld_req,
  input logic [IDX_W-1:0] ld_idx,
  input logic             handoff,
  input logic [IDX_W-1:0] handoff_idx,
  input logic [IDX_W-1:0] last_idx,
  input logic [SW_W-1:0]  state_word,
  input logic             fallback_sel
);

  p_cold_idx0_r2: assert property (@(posedge clk) disable iff (rst)
    cold_rst_req |=> (ld_req && ld_idx == '0 && !fallback_sel));

  p_handoff_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    handoff |=> !handoff);

  p_last_matches_r3: assert property (@(posedge clk) disable iff (rst)
    handoff |-> (last_idx == handoff_idx));

  p_no_handoff_in_fb_r5: assert property (@(posedge clk) disable iff (rst)
    !(handoff && fallback_sel));

  p_fb_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (fallback_sel && !cold_rst_req) |=> fallback_sel);

  p_fb_no_load_r9: assert property (@(posedge clk) disable iff (rst)
    (fallback_sel && !cold_rst_req) |=> !ld_req);

  p_word_clear_r10: assert property (@(posedge clk) disable iff (rst)
    handoff |-> (state_word == '0));

endmodule

bind boot_img_sel bsel_chk #(.IDX_W(IDX_W), .SW_W(SW_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cold_rst_req (cold_rst_req),
  .ld_req       (ld_req),
  .ld_idx       (ld_idx),
  .handoff      (handoff),
  .handoff_idx  (handoff_idx),
  .last_idx     (last_idx),
  .state_word   (state_word),
  .fallback_sel (fallback_sel)
);

// File: tb/sim_boot_img_sel.sv
module sim_boot_img_sel;

  localparam int          NUM_IMG = 4;
  localparam int          IDX_W   = 2;
  localparam int          SW_W    = 32;
  localparam logic [31:0] PROOF   = 32'h4953_5756;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cold_rst_req = 1'b0;
  logic             warm_rst_req = 1'b0;
  logic             ld_req;
  logic [IDX_W-1:0] ld_idx;
  logic             ld_done = 1'b0;
  logic             ld_pass = 1'b0;
  logic             sw_wr_en = 1'b0;
  logic [SW_W-1:0]  sw_wr_data = '0;
  logic [SW_W-1:0]  state_word;
  logic [IDX_W-1:0] last_idx;
  logic             handoff;
  logic [IDX_W-1:0] handoff_idx;
  logic             fallback_sel;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  boot_img_sel #(.NUM_IMG(NUM_IMG), .SW_W(SW_W)) u0 (
    .clk(clk), .rst(rst), .cold_rst_req(cold_rst_req), .warm_rst_req(warm_rst_req),
    .ld_req(ld_req), .ld_idx(ld_idx), .ld_done(ld_done), .ld_pass(ld_pass),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .state_word(state_word),
    .last_idx(last_idx), .handoff(handoff), .handoff_idx(handoff_idx),
    .fallback_sel(fallback_sel)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge; inputs set here are seen at the next rising edge.
  task automatic step();
    @(negedge clk);
    cold_rst_req = 1'b0; warm_rst_req = 1'b0;
    ld_done = 1'b0; ld_pass = 1'b0; sw_wr_en = 1'b0;
  endtask

  task automatic answer(input logic pass);
    ld_done = 1'b1; ld_pass = pass; step();
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ld_req in reset", 32'(ld_req), 0);
    chk("R1", "fallback in reset", 32'(fallback_sel), 0);
    rst = 1'b0;
    step();
    chk("R1", "ld_req", 32'(ld_req), 0);
    chk("R1", "handoff", 32'(handoff), 0);
    chk("R1", "fallback_sel", 32'(fallback_sel), 0);
    chk("R1", "last_idx", 32'(last_idx), 0);
    chk("R1", "state_word", state_word, 0);
  endtask

  task automatic t_warm_before_cold();
    sw_wr_en = 1'b1; sw_wr_data = PROOF; step();
    chk("R10", "word after write", state_word, PROOF);
    warm_rst_req = 1'b1; step();
    chk("R11", "ld_req", 32'(ld_req), 1);
    chk("R11", "ld_idx", 32'(ld_idx), 0);
    answer(1'b1);
    chk("R3", "handoff", 32'(handoff), 1);
    chk("R3", "handoff_idx", 32'(handoff_idx), 0);
    chk("R3", "last_idx", 32'(last_idx), 0);
    chk("R10", "word cleared at handoff", state_word, 0);
    step();
    chk("R3", "handoff one cycle", 32'(handoff), 0);
  endtask

  task automatic t_cold_chain();
    cold_rst_req = 1'b1; step();
    chk("R2", "ld_req", 32'(ld_req), 1);
    chk("R2", "ld_idx", 32'(ld_idx), 0);
    step();
    chk("R2", "ld_req drops", 32'(ld_req), 0);
    answer(1'b0);
    chk("R4", "retry ld_req", 32'(ld_req), 1);
    chk("R4", "retry idx 1", 32'(ld_idx), 1);
    answer(1'b0);
    chk("R4", "retry idx 2", 32'(ld_idx), 2);
    answer(1'b1);
    chk("R3", "handoff", 32'(handoff), 1);
    chk("R3", "handoff_idx", 32'(handoff_idx), 2);
    chk("R3", "last_idx", 32'(last_idx), 2);
  endtask

  task automatic t_warm_proof();
    sw_wr_en = 1'b1; sw_wr_data = PROOF; step();
    warm_rst_req = 1'b1; step();
    chk("R6", "reload ld_req", 32'(ld_req), 1);
    chk("R6", "reload idx", 32'(ld_idx), 2);
    answer(1'b1);
    chk("R6", "handoff idx", 32'(handoff_idx), 2);
  endtask

  task automatic t_warm_advance();
    warm_rst_req = 1'b1; step();
    chk("R7", "ld_req", 32'(ld_req), 1);
    chk("R7", "next idx", 32'(ld_idx), 3);
    chk("R7", "last_idx bumped", 32'(last_idx), 3);
    answer(1'b1);
    chk("R7", "handoff idx", 32'(handoff_idx), 3);
  endtask

  task automatic t_warm_exhaust();
    warm_rst_req = 1'b1; step();
    chk("R8", "fallback_sel", 32'(fallback_sel), 1);
    chk("R8", "no ld_req", 32'(ld_req), 0);
  endtask

  task automatic t_sticky();
    sw_wr_en = 1'b1; sw_wr_data = PROOF; step();
    warm_rst_req = 1'b1; step();
    chk("R9", "fallback holds", 32'(fallback_sel), 1);
    chk("R9", "no ld_req", 32'(ld_req), 0);
    answer(1'b1);
    chk("R9", "done ignored", 32'(handoff), 0);
    chk("R9", "fallback still", 32'(fallback_sel), 1);
    cold_rst_req = 1'b1; step();
    chk("R9", "cold clears", 32'(fallback_sel), 0);
    chk("R2", "cold loads 0", 32'(ld_req), 1);
  endtask

  task automatic t_cold_exhaust();
    answer(1'b0); answer(1'b0); answer(1'b0);
    chk("R4", "reached top idx", 32'(ld_idx), 3);
    answer(1'b0);
    chk("R5", "fallback_sel", 32'(fallback_sel), 1);
    chk("R5", "no ld_req", 32'(ld_req), 0);
    chk("R5", "no handoff", 32'(handoff), 0);
  endtask

  task automatic t_collisions();
    cold_rst_req = 1'b1; warm_rst_req = 1'b1; step();
    chk("R12", "cold wins ld_idx", 32'(ld_idx), 0);
    chk("R12", "cold wins ld_req", 32'(ld_req), 1);
    chk("R12", "cold wins fallback", 32'(fallback_sel), 0);
    warm_rst_req = 1'b1; answer(1'b1);
    chk("R12", "done discarded", 32'(handoff), 0);
    chk("R12", "warm reload idx", 32'(ld_idx), 3);
    chk("R12", "warm reload req", 32'(ld_req), 1);
    answer(1'b1);
    chk("R12", "later handoff idx", 32'(handoff_idx), 3);
  endtask

  task automatic t_clear_vs_write();
    cold_rst_req = 1'b1; step();
    sw_wr_en = 1'b1; sw_wr_data = PROOF; answer(1'b1);
    chk("R10", "handoff", 32'(handoff), 1);
    chk("R10", "clear wins in handoff cycle", state_word, 0);
    step();
    chk("R10", "clear wins next cycle", state_word, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_warm_before_cold();
    t_cold_chain();
    t_warm_proof();
    t_warm_advance();
    t_warm_exhaust();
    t_sticky();
    t_cold_exhaust();
    t_collisions();
    t_clear_vs_write();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog (all): actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule